// File: doc/BRIEF.md
# Memory Address Generation Unit

This block forms the 64-bit effective address of a memory operand from three terms: a base pointer, an optional index scaled by the operand size, and an optional sign-extended constant displacement. The base comes from a general register value or from one of four special pointers: instruction, data-section, thread-data or stack. The index term is multiplied by the operand size for scalar and broadcast accesses, taken unscaled for vector accesses, or subtracted. The subtracting mode lets a loop walk an array from its end by counting a byte index down to zero.

The same unit also produces branch and call destinations. In that case the address is the instruction pointer plus a signed word displacement. An optional unsigned upper bound on the index raises a bounds-trap flag. That flag reaches the output in the same cycle as the address it belongs to.

Each request is presented for one cycle with `req_valid`. The result appears one clock later with `out_valid`. Arithmetic wraps modulo 2^64.

Top module: `agu_top`

## Requirements
- R1: For data accesses (`is_jump`=0), `base_sel` picks the base as follows: 0 selects `gpr_base`, 1 selects `ip_val`, 2 selects `data_ptr`, 3 selects `thread_ptr` and 4 selects `stack_ptr`. Codes 5 to 7 select `gpr_base`.
- R2: An `idx_num` of 31 means no index. The index term is then zero whatever `idx_val` holds.
- R3: When an index is present, `scale_mode` 0 adds `idx_val` shifted left by `size_log2`, where the operand size is 2^size_log2 bytes. Modes 1 and 3 add `idx_val` unscaled.
- R4: When an index is present, `scale_mode` 2 subtracts `idx_val` from the base.
- R5: For data accesses, `ofs_width` selects the displacement as follows:
  - 0: zero;
  - 1: `ofs_raw[7:0]` sign-extended, then shifted left by `size_log2`;
  - 2: `ofs_raw[15:0]` sign-extended, with no multiplier;
  - 3: `ofs_raw[31:0]` sign-extended, with no multiplier.
- R6: `out_trap` is 1 only when all of these hold for the data access it belongs to: `limit_en` is 1, an index is present, and `idx_val` is greater than `limit_val` in an unsigned comparison. A branch target never traps.
- R7: When `is_jump` is 1, the address is `ip_val` plus four times the sign extension of `ofs_raw`. Its width is set by `ofs_width`: 8 bits for code 0, 16 for 1, 24 for 2 and 32 for 3. The base selection and the index have no effect on a branch target.
- R8: `out_valid` equals `req_valid` delayed by one clock, and the address and trap of a request appear in that same cycle. After a cycle with `req_valid` low, `out_valid` and `out_trap` are 0 and `out_addr` keeps its previous value.
- R9: While `rst_n` is low, `out_valid`, `out_trap` and `out_addr` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| is_jump | input | 1 | 1: branch/call target, 0: data operand |
| base_sel | input | 3 | Base pointer selection code |
| gpr_base | input | 64 | General register value used as base |
| ip_val | input | 64 | Instruction pointer |
| data_ptr | input | 64 | Data-section pointer |
| thread_ptr | input | 64 | Thread-data pointer |
| stack_ptr | input | 64 | Stack pointer |
| idx_num | input | 5 | Index register number, 31 = none |
| idx_val | input | 64 | Index register value |
| scale_mode | input | 2 | 0 element size, 1/3 unit, 2 negate |
| size_log2 | input | 3 | log2 of operand size in bytes |
| ofs_raw | input | 32 | Raw displacement bits |
| ofs_width | input | 2 | Displacement width code |
| limit_en | input | 1 | Enable the unsigned index bound |
| limit_val | input | 64 | Index upper bound |
| out_valid | output | 1 | Result valid |
| out_addr | output | 64 | Effective address |
| out_trap | output | 1 | Index bound exceeded |

## Verification
The bounds trap and the negated-index address can arise in one request, and both must then appear in the same output cycle. The bench provokes this with directed subtract-mode requests whose limit lies just below, at, and just above the index. Random requests also draw limits close to the index value. Each such request is judged on both the address and the trap flag in the single cycle after it is issued.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic [2:0] {
        BASE_GPR    = 3'd0,
        BASE_IP     = 3'd1,
        BASE_DATA   = 3'd2,
        BASE_THREAD = 3'd3,
        BASE_STACK  = 3'd4
    } base_sel_e;

    typedef enum logic [1:0] {
        SCALE_ELEM = 2'd0,
        SCALE_UNIT = 2'd1,
        SCALE_NEG  = 2'd2,
        SCALE_ALT  = 2'd3
    } scale_e;

    typedef enum logic [1:0] {
        OFS_NONE = 2'd0,
        OFS_B8   = 2'd1,
        OFS_B16  = 2'd2,
        OFS_B32  = 2'd3
    } ofs_width_e;

endpackage

// File: rtl/agu_base_mux.sv
module agu_base_mux
    import agu_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic [2:0]        sel,
    input  logic [ADDR_W-1:0] gpr_base,
    input  logic [ADDR_W-1:0] ip_val,
    input  logic [ADDR_W-1:0] data_ptr,
    input  logic [ADDR_W-1:0] thread_ptr,
    input  logic [ADDR_W-1:0] stack_ptr,
    output logic [ADDR_W-1:0] base
);
    always_comb begin
        unique case (sel)
            BASE_IP:     base = ip_val;
            BASE_DATA:   base = data_ptr;
            BASE_THREAD: base = thread_ptr;
            BASE_STACK:  base = stack_ptr;
            default:     base = gpr_base;
        endcase
    end
endmodule

// File: rtl/agu_index_term.sv
module agu_index_term
    import agu_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int REG_IDX_W = 5,
    parameter int SIZE_W    = 3
) (
    input  logic [REG_IDX_W-1:0] idx_num,
    input  logic [ADDR_W-1:0]    idx_val,
    input  logic [1:0]           scale_mode,
    input  logic [SIZE_W-1:0]    size_log2,
    output logic                 present,
    output logic [ADDR_W-1:0]    term
);
    localparam logic [REG_IDX_W-1:0] NO_INDEX = '1;

    logic [ADDR_W-1:0] scaled;

    always_comb begin
        present = (idx_num != NO_INDEX);
        unique case (scale_mode)
            SCALE_ELEM: scaled = idx_val << size_log2;
            SCALE_NEG:  scaled = ~idx_val + {{(ADDR_W-1){1'b0}}, 1'b1};
            default:    scaled = idx_val;
        endcase
        term = present ? scaled : '0;
    end
endmodule

// File: rtl/agu_offset_ext.sv
module agu_offset_ext
    import agu_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int OFS_W  = 32,
    parameter int SIZE_W = 3
) (
    input  logic [OFS_W-1:0]  ofs_raw,
    input  logic [1:0]        ofs_width,
    input  logic              is_jump,
    input  logic [SIZE_W-1:0] size_log2,
    output logic [ADDR_W-1:0] ofs
);
    localparam int WORD_SHIFT = 2;

    logic [ADDR_W-1:0] sx8, sx16, sx24, sx32;
    logic [ADDR_W-1:0] jump_ofs;

    always_comb begin
        sx8  = {{(ADDR_W-8){ofs_raw[7]}},   ofs_raw[7:0]};
        sx16 = {{(ADDR_W-16){ofs_raw[15]}}, ofs_raw[15:0]};
        sx24 = {{(ADDR_W-24){ofs_raw[23]}}, ofs_raw[23:0]};
        sx32 = {{(ADDR_W-32){ofs_raw[31]}}, ofs_raw[31:0]};
        unique case (ofs_width)
            2'd0:    jump_ofs = sx8;
            2'd1:    jump_ofs = sx16;
            2'd2:    jump_ofs = sx24;
            default: jump_ofs = sx32;
        endcase
        if (is_jump) begin
            ofs = jump_ofs << WORD_SHIFT;
        end else begin
            unique case (ofs_width)
                OFS_B8:  ofs = sx8 << size_log2;
                OFS_B16: ofs = sx16;
                OFS_B32: ofs = sx32;
                default: ofs = '0;
            endcase
        end
    end
endmodule

// File: rtl/agu_top.sv
module agu_top
    import agu_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int OFS_W     = 32,
    parameter int REG_IDX_W = 5,
    parameter int SIZE_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 is_jump,
    input  logic [2:0]           base_sel,
    input  logic [ADDR_W-1:0]    gpr_base,
    input  logic [ADDR_W-1:0]    ip_val,
    input  logic [ADDR_W-1:0]    data_ptr,
    input  logic [ADDR_W-1:0]    thread_ptr,
    input  logic [ADDR_W-1:0]    stack_ptr,
    input  logic [REG_IDX_W-1:0] idx_num,
    input  logic [ADDR_W-1:0]    idx_val,
    input  logic [1:0]           scale_mode,
    input  logic [SIZE_W-1:0]    size_log2,
    input  logic [OFS_W-1:0]     ofs_raw,
    input  logic [1:0]           ofs_width,
    input  logic                 limit_en,
    input  logic [ADDR_W-1:0]    limit_val,
    output logic                 out_valid,
    output logic [ADDR_W-1:0]    out_addr,
    output logic                 out_trap
);
    localparam logic [REG_IDX_W-1:0] NO_INDEX = '1;

    typedef struct packed {
        logic              valid;
        logic              trap;
        logic [ADDR_W-1:0] addr;
    } agu_state_t;

    agu_state_t state_d, state_q;

    logic [ADDR_W-1:0] base_w, idx_term_w, ofs_w;
    logic              idx_present_w;

    agu_base_mux #(.ADDR_W(ADDR_W)) base_mux_i (
        .sel        (base_sel),
        .gpr_base   (gpr_base),
        .ip_val     (ip_val),
        .data_ptr   (data_ptr),
        .thread_ptr (thread_ptr),
        .stack_ptr  (stack_ptr),
        .base       (base_w)
    );

    agu_index_term #(.ADDR_W(ADDR_W), .REG_IDX_W(REG_IDX_W), .SIZE_W(SIZE_W)) index_i (
        .idx_num    (idx_num),
        .idx_val    (idx_val),
        .scale_mode (scale_mode),
        .size_log2  (size_log2),
        .present    (idx_present_w),
        .term       (idx_term_w)
    );

    agu_offset_ext #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .SIZE_W(SIZE_W)) offset_i (
        .ofs_raw    (ofs_raw),
        .ofs_width  (ofs_width),
        .is_jump    (is_jump),
        .size_log2  (size_log2),
        .ofs        (ofs_w)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = req_valid;
        state_d.trap  = 1'b0;
        if (req_valid) begin
            if (is_jump) begin
                state_d.addr = ip_val + ofs_w;
            end else begin
                state_d.addr = base_w + idx_term_w + ofs_w;
                state_d.trap = limit_en && idx_present_w && (idx_val > limit_val);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.valid;
    assign out_trap  = state_q.trap;
    assign out_addr  = state_q.addr;

    // R8
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    // R8
    valid_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(req_valid));

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(out_addr) && !out_trap);

    // R6
    trap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_trap |-> $past(limit_en) && !$past(is_jump) && ($past(idx_num) != NO_INDEX));

    // R6
    trap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_trap |-> out_valid && ($past(idx_val) > $past(limit_val)));

    // R7
    jump_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && is_jump && (ip_val[1:0] == 2'b00) |=> out_addr[1:0] == 2'b00);

endmodule

// File: tb/agu_top_tb.sv
module agu_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rv, jmp, len;
    logic [2:0]  bsel, slog;
    logic [63:0] gpr, ipv, dpv, tpv, spv, ival, lim;
    logic [4:0]  inum;
    logic [1:0]  smode, owid;
    logic [31:0] oraw;
    logic        o_valid, o_trap;
    logic [63:0] o_addr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [63:0] last_addr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    agu_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(rv), .is_jump(jmp),
        .base_sel(bsel), .gpr_base(gpr), .ip_val(ipv), .data_ptr(dpv),
        .thread_ptr(tpv), .stack_ptr(spv), .idx_num(inum), .idx_val(ival),
        .scale_mode(smode), .size_log2(slog), .ofs_raw(oraw), .ofs_width(owid),
        .limit_en(len), .limit_val(lim),
        .out_valid(o_valid), .out_addr(o_addr), .out_trap(o_trap)
    );

    function automatic logic [63:0] sx(logic [31:0] v, int bits);
        logic [63:0] t;
        t = {32'b0, v} << (64 - bits);
        return $unsigned($signed(t) >>> (64 - bits));
    endfunction

    function automatic logic [63:0] exp_addr();
        logic [63:0] b, it, of;
        if (jmp) return ipv + (sx(oraw, 8 * (int'(owid) + 1)) << 2);
        case (bsel)
            3'd1: b = ipv;
            3'd2: b = dpv;
            3'd3: b = tpv;
            3'd4: b = spv;
            default: b = gpr;
        endcase
        if (inum == 5'd31) it = 64'd0;
        else if (smode == 2'd0) it = ival << slog;
        else if (smode == 2'd2) it = 64'd0 - ival;
        else it = ival;
        case (owid)
            2'd1: of = sx(oraw, 8) << slog;
            2'd2: of = sx(oraw, 16);
            2'd3: of = sx(oraw, 32);
            default: of = 64'd0;
        endcase
        return b + it + of;
    endfunction

    function automatic logic exp_trap();
        return !jmp && len && (inum != 5'd31) && (ival > lim);
    endfunction

    task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] expv);
        checks++;
        if (got !== expv) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, got, expv);
        end
    endtask

    task automatic idle_defaults();
        rv = 1'b0; jmp = 1'b0; len = 1'b0; bsel = 3'd0; slog = 3'd0;
        gpr = 64'h1000; ipv = 64'h4000; dpv = 64'h8000; tpv = 64'hC000;
        spv = 64'hF000; ival = 64'd0; lim = 64'd0; inum = 5'd31;
        smode = 2'd1; owid = 2'd0; oraw = 32'd0;
    endtask

    // inputs already set at a negedge; result checked at the next negedge
    task automatic issue(string tag);
        logic [63:0] ea;
        logic et;
        logic ev;
        ev = rv;
        ea = rv ? exp_addr() : last_addr;
        et = rv ? exp_trap() : 1'b0;
        @(negedge clk);
        chk(tag, "valid", {63'd0, o_valid}, {63'd0, ev});
        chk(tag, "addr", o_addr, ea);
        chk(tag, "trap", {63'd0, o_trap}, {63'd0, et});
        last_addr = ea;
    endtask

    task automatic data_req(logic [2:0] bs, logic [4:0] n, logic [63:0] v,
                            logic [1:0] sm, logic [2:0] sl, logic [31:0] r, logic [1:0] w);
        rv = 1'b1; jmp = 1'b0; bsel = bs; inum = n; ival = v;
        smode = sm; slog = sl; oraw = r; owid = w;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        idle_defaults();
        rst_n = 1'b0;
        rv = 1'b1;
        repeat (3) @(negedge clk);
        // R9: reset holds outputs at zero
        chk("R9", "valid", {63'd0, o_valid}, 64'd0);
        chk("R9", "addr", o_addr, 64'd0);
        chk("R9", "trap", {63'd0, o_trap}, 64'd0);
        rst_n = 1'b1;
        rv = 1'b0;
        issue("R9");

        // R1: every base selection, including the codes above 4
        for (int s = 0; s < 8; s++) begin
            data_req(3'(s), 5'd31, 64'hDEAD, 2'd0, 3'd0, 32'd0, 2'd0);
            issue("R1");
        end

        // R2: index field 31 ignores a huge index value
        data_req(3'd0, 5'd31, 64'hFFFF_FFFF_FFFF_FFF0, 2'd0, 3'd3, 32'd0, 2'd0);
        issue("R2");

        // R3: element scaling and unit scaling
        data_req(3'd0, 5'd4, 64'd5, 2'd0, 3'd3, 32'd0, 2'd0);
        issue("R3");
        data_req(3'd0, 5'd4, 64'd5, 2'd1, 3'd3, 32'd0, 2'd0);
        issue("R3");
        data_req(3'd0, 5'd4, 64'd5, 2'd3, 3'd4, 32'd0, 2'd0);
        issue("R3");

        // R4: subtract mode, alone and together with the bound trap (R6)
        data_req(3'd4, 5'd7, 64'd16, 2'd2, 3'd3, 32'd0, 2'd0);
        issue("R4");
        len = 1'b1; lim = 64'd15;
        issue("R4");
        lim = 64'd16;
        issue("R4");
        lim = 64'd17;
        issue("R4");
        len = 1'b0;

        // R5: offset widths and the 8-bit multiplier
        data_req(3'd0, 5'd31, 64'd0, 2'd0, 3'd2, 32'h0000_00FF, 2'd1);
        issue("R5");
        data_req(3'd0, 5'd31, 64'd0, 2'd0, 3'd3, 32'h0000_007F, 2'd1);
        issue("R5");
        data_req(3'd0, 5'd31, 64'd0, 2'd0, 3'd3, 32'h0000_8000, 2'd2);
        issue("R5");
        data_req(3'd0, 5'd31, 64'd0, 2'd0, 3'd3, 32'h8000_0000, 2'd3);
        issue("R5");
        data_req(3'd0, 5'd31, 64'd0, 2'd0, 3'd3, 32'hFFFF_FFFF, 2'd0);
        issue("R5");

        // R6: unsigned compare, disabled limit, absent index
        data_req(3'd0, 5'd2, 64'hFFFF_FFFF_FFFF_FFFF, 2'd1, 3'd0, 32'd0, 2'd0);
        len = 1'b1; lim = 64'd5;
        issue("R6");
        len = 1'b0;
        issue("R6");
        len = 1'b1; inum = 5'd31;
        issue("R6");
        len = 1'b0;

        // R7: branch targets ignore base, index and limit
        rv = 1'b1; jmp = 1'b1; bsel = 3'd4; inum = 5'd3; ival = 64'd999;
        len = 1'b1; lim = 64'd0;
        for (int w = 0; w < 4; w++) begin
            owid = 2'(w); oraw = 32'h8080_8080;
            issue("R7");
            oraw = 32'h0012_3401;
            issue("R7");
        end
        jmp = 1'b0; len = 1'b0;

        // R8: idle cycle holds the address and drops valid
        rv = 1'b0; gpr = 64'h1234_5678;
        issue("R8");
        issue("R8");

        // random mix, limits drawn near the index value
        for (int i = 0; i < 600; i++) begin
            rv    = ($urandom % 8) != 0;
            jmp   = ($urandom % 6) == 0;
            bsel  = 3'($urandom);
            gpr   = {$urandom, $urandom}; ipv = {$urandom, $urandom};
            dpv   = {$urandom, $urandom}; tpv = {$urandom, $urandom};
            spv   = {$urandom, $urandom};
            inum  = 5'($urandom);
            ival  = ($urandom % 2) ? {$urandom, $urandom} : 64'($urandom % 512);
            smode = 2'($urandom); slog = 3'($urandom % 5);
            oraw  = $urandom; owid = 2'($urandom);
            len   = $urandom % 2;
            lim   = ival + 64'($urandom % 3) - 64'd1;
            issue(jmp ? "R7" : (smode == 2'd2 ? "R4" : "R3"));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule